// File: doc/BRIEF.md
# Multiplexed Address/Data Host Bus Slave

This block lets an external host reach a small internal register file over a bus that carries the address and then the data on the same wires. The host places a word address on the bus while the address-latch strobe is high, with address bit 1 on its own pin. In a later phase of the same cycle it moves one 16-bit word, in either direction. Byte accesses do not exist: bus bit 0 and bus bit 1 never take part in decoding.

A static mode pin selects one of two host protocols. The first is a fixed-length protocol: address phase, a parameterised number of wait phases (four by default), one data phase and one recovery phase. A ready strobe is pulled low for exactly the data and recovery phases and is floated at every other time. The second is a generic asynchronous protocol, paced by an active-low data strobe and with no ready strobe.

The register file holds a control word, an interrupt-enable word, a write-one-to-clear status word fed by hardware set pulses, and a bank of scratch words. Words cross the bus in big-endian byte order after reset, and a control bit switches them to little-endian. An open-drain, active-low interrupt request is pulled low while any enabled status bit is set.

Top module: `hb_slave`

## Requirements
- R1: After reset the byte order is big endian, the enable and status words read zero, and the ready pad, the interrupt pad and the bus output enable are all released.
- R2: With `mode_generic`=0, a cycle starts on a clock edge that sees `cs_n` low and `ale` high, and runs through WAITS wait phases, one data phase and one recovery phase. `rdy_low_oe` is 1 during the data phase and the recovery phase only, which is exactly two cycles per access.
- R3: The word index is {ad_in[ADDR_W-1:2], a1}, captured with `ale`. Bus bits 1 and 0 have no effect on the selected word.
- R4: A 16-bit write followed by a read of the same scratch word (index 3 to NREG-1) returns the written bus value while the byte order is unchanged.
- R5: Control word bit 0 (register byte order) set to 1 selects little endian. In big endian the bus and register bytes are swapped, bus[15:8] carrying register bits [7:0]. Both writes and reads pass through the swap.
- R6: With `mode_generic`=1, a write takes the data present while `ds_n` was low and stores it when `ds_n` returns high. Read data is driven only while `cs_n`, `ds_n` are low and `wr_rd` is 0. The ready pad is never driven in this mode.
- R7: `cs_n` going high before the data phase ends aborts the cycle: no register changes, the state machine returns to idle, and the ready pad is not driven.
- R8: Status word (index 2) bits are set by one-cycle pulses on `status_set`. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R9: `irq_low_oe` is 1 exactly while some status bit and its enable bit (index 1) are both 1.
- R10: A word index of NREG or above ignores writes and reads as zero.
- R11: `ad_oe` is 1 only during a read data phase while `cs_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_generic | input | 1 | Static protocol select: 0 fixed-length with ready strobe, 1 generic |
| cs_n | input | 1 | Chip select, active low |
| ale | input | 1 | Address-latch enable |
| a1 | input | 1 | Address bit 1 on its own pin |
| wr_rd | input | 1 | Direction: 1 write, 0 read |
| ds_n | input | 1 | Generic-mode data strobe, active low |
| ad_in | input | 16 | Multiplexed address/data bus, incoming value |
| ad_out | output | 16 | Read data presented on the bus |
| ad_oe | output | 1 | Bus output enable |
| rdy_low_oe | output | 1 | Ready pad: 1 pulls low, 0 floats |
| status_set | input | NSTAT | Hardware pulses that set status bits |
| irq_low_oe | output | 1 | Open-drain interrupt pad: 1 pulls low, 0 floats |

## Verification
The bench keeps the defaults: ADDR_W=8, NREG=8, NSTAT=8 and WAITS=4. With these values the fixed-length frame is seven cycles, so the ready pulse can be checked edge by edge. Five scratch words give random traffic room to collide. The 7-bit index space leaves indices 8 to 127 to probe the out-of-range behaviour, and the bench aliases them against a real word. Random traffic changes the protocol mode and the byte order between accesses, so swapped and unswapped paths are both covered in both protocols.

// File: rtl/hb_pkg.sv
// Package: shared state encoding and byte-lane helper for the host bus slave.
// Assumes a 16-bit bus word.
package hb_pkg;
    localparam int WORD_W = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_DATA,
        ST_REC,
        ST_GACT
    } cyc_state_t;

    // Exchange the two bytes of a word when en is set.
    function automatic logic [WORD_W-1:0] lane_swap(input logic [WORD_W-1:0] v, input logic en);
        return en ? {v[7:0], v[15:8]} : v;
    endfunction
endpackage

// File: rtl/hb_cycle_fsm.sv
// Module: bus cycle sequencer. Latches the word index on ale, then runs either
// the fixed-length frame (wait phases, data, recovery) or the strobe-paced
// generic cycle. Emits a one-cycle write enable, the read-drive window and
// the ready pad enable. Assumes mode_generic is static while a cycle is open.
module hb_cycle_fsm
    import hb_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int WAITS  = 4,
    localparam int IDX_W = ADDR_W - 1,
    localparam int CNT_W = $clog2(WAITS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_generic,
    input  logic              cs_n,
    input  logic              ale,
    input  logic              a1,
    input  logic              wr_rd,
    input  logic              ds_n,
    input  logic [ADDR_W-1:2] ad_addr,
    input  logic [WORD_W-1:0] ad_data,
    output logic [IDX_W-1:0]  idx,
    output logic              wr_en,
    output logic [WORD_W-1:0] wr_data,
    output logic              rd_drive,
    output logic              rdy_drv
);
    cyc_state_t        state;
    logic [CNT_W-1:0]  cnt;
    logic              ds_seen;
    logic [WORD_W-1:0] cap;

    // Cycle state, wait counter, latched index and generic-mode data capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            idx     <= '0;
            ds_seen <= 1'b0;
            cap     <= '0;
        end else if (state == ST_IDLE) begin
            if (!cs_n && ale) begin
                idx     <= {ad_addr, a1};
                state   <= mode_generic ? ST_GACT : ST_WAIT;
                cnt     <= '0;
                ds_seen <= 1'b0;
            end
        end else if (cs_n) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_WAIT: begin
                    if (cnt == CNT_W'(WAITS - 1)) state <= ST_DATA;
                    else                          cnt   <= cnt + 1'b1;
                end
                ST_DATA: state <= ST_REC;
                ST_REC:  state <= ST_IDLE;
                ST_GACT: begin
                    if (!ds_n) begin
                        ds_seen <= 1'b1;
                        cap     <= ad_data;
                    end else if (ds_seen) begin
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Strobe decode: write pulse, read window, ready pad and write data source.
    always_comb begin
        wr_en    = !cs_n && wr_rd &&
                   ((state == ST_DATA) || (state == ST_GACT && ds_seen && ds_n));
        rd_drive = !cs_n && !wr_rd &&
                   ((state == ST_DATA) || (state == ST_GACT && !ds_n));
        rdy_drv  = (state == ST_DATA) || (state == ST_REC);
        wr_data  = (state == ST_GACT) ? cap : ad_data;
    end
endmodule

// File: rtl/hb_regfile.sv
// Module: register file. Index 0 control (bit 0 little endian), 1 interrupt
// enable, 2 write-one-to-clear status, 3..NREG-1 scratch words. Indices at
// or above NREG read zero. Values are in register byte order.
module hb_regfile
    import hb_pkg::*;
#(
    parameter int NREG  = 8,
    parameter int NSTAT = 8,
    parameter int IDX_W = 7,
    localparam int BASE  = 3,
    localparam int SCR_N = NREG - BASE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  idx,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_word,
    input  logic [NSTAT-1:0]  status_set,
    output logic [WORD_W-1:0] rd_word,
    output logic              little_en,
    output logic              irq_pull
);
    logic [NSTAT-1:0]  ien;
    logic [NSTAT-1:0]  stat;
    logic [NSTAT-1:0]  clr;
    logic [WORD_W-1:0] scr [SCR_N];

    // Control and enable words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            little_en <= 1'b0;
            ien       <= '0;
        end else if (wr_en) begin
            if (int'(idx) == 0) little_en <= wr_word[0];
            if (int'(idx) == 1) ien       <= wr_word[NSTAT-1:0];
        end
    end

    // Clear mask from a write to the status word.
    always_comb clr = (wr_en && int'(idx) == 2) ? wr_word[NSTAT-1:0] : '0;

    // Status bits: hardware set wins over host clear.
    always_ff @(posedge clk) begin
        if (!rst_n) stat <= '0;
        else        stat <= (stat & ~clr) | status_set;
    end

    // One storage process per scratch word.
    for (genvar g = 0; g < SCR_N; g++) begin : g_scr
        always_ff @(posedge clk) begin
            if (!rst_n)                               scr[g] <= '0;
            else if (wr_en && int'(idx) == g + BASE)  scr[g] <= wr_word;
        end
    end

    // Read multiplexer.
    always_comb begin
        rd_word = '0;
        if (int'(idx) == 0) rd_word[0] = little_en;
        if (int'(idx) == 1) rd_word[NSTAT-1:0] = ien;
        if (int'(idx) == 2) rd_word[NSTAT-1:0] = stat;
        for (int k = 0; k < SCR_N; k++)
            if (int'(idx) == k + BASE) rd_word = scr[k];
    end

    // Interrupt request level.
    always_comb irq_pull = |(stat & ien);
endmodule

// File: rtl/hb_slave.sv
// Module: top of the host bus slave. Joins the cycle sequencer and register
// file and applies the endian byte swap on both directions. Pads are modelled
// as enables: the ready and interrupt pads pull low when their enable is 1.
module hb_slave
    import hb_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int NREG   = 8,
    parameter int NSTAT  = 8,
    parameter int WAITS  = 4,
    localparam int IDX_W = ADDR_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_generic,
    input  logic              cs_n,
    input  logic              ale,
    input  logic              a1,
    input  logic              wr_rd,
    input  logic              ds_n,
    input  logic [15:0]       ad_in,
    output logic [15:0]       ad_out,
    output logic              ad_oe,
    output logic              rdy_low_oe,
    input  logic [NSTAT-1:0]  status_set,
    output logic              irq_low_oe
);
    logic [IDX_W-1:0]  idx;
    logic              wr_en;
    logic [WORD_W-1:0] wr_data;
    logic [WORD_W-1:0] rd_word;
    logic              rd_drive;
    logic              little_en;

    hb_cycle_fsm #(.ADDR_W(ADDR_W), .WAITS(WAITS)) u_fsm (
        .clk(clk), .rst_n(rst_n), .mode_generic(mode_generic), .cs_n(cs_n),
        .ale(ale), .a1(a1), .wr_rd(wr_rd), .ds_n(ds_n),
        .ad_addr(ad_in[ADDR_W-1:2]), .ad_data(ad_in), .idx(idx),
        .wr_en(wr_en), .wr_data(wr_data), .rd_drive(rd_drive), .rdy_drv(rdy_low_oe)
    );

    hb_regfile #(.NREG(NREG), .NSTAT(NSTAT), .IDX_W(IDX_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .idx(idx), .wr_en(wr_en),
        .wr_word(lane_swap(wr_data, !little_en)), .status_set(status_set),
        .rd_word(rd_word), .little_en(little_en), .irq_pull(irq_low_oe)
    );

    // Bus-side read value and its enable.
    always_comb begin
        ad_out = lane_swap(rd_word, !little_en);
        ad_oe  = rd_drive;
    end
endmodule

// File: rtl/hb_slave_chk.sv
// Module: temporal checks for hb_slave, attached by bind.
module hb_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic mode_generic,
    input logic cs_n,
    input logic wr_rd,
    input logic ad_oe,
    input logic rdy_low_oe,
    input logic wr_en
);
    assert_rdy_second_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdy_low_oe) && !cs_n |=> rdy_low_oe);
    assert_rdy_two_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_low_oe && $past(rdy_low_oe) |=> !rdy_low_oe);
    assert_rdy_generic_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mode_generic && $stable(mode_generic) |-> !rdy_low_oe);
    assert_write_needs_cs_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !cs_n);
    assert_oe_read_only_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ad_oe |-> (!cs_n && !wr_rd));
endmodule

bind hb_slave hb_slave_chk u_chk (
    .clk(clk), .rst_n(rst_n), .mode_generic(mode_generic), .cs_n(cs_n),
    .wr_rd(wr_rd), .ad_oe(ad_oe), .rdy_low_oe(rdy_low_oe), .wr_en(wr_en)
);

// File: tb/sim_hb_slave.sv
// Bench for hb_slave: directed corner cases plus seeded random traffic.
module sim_hb_slave;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_generic = 1'b0, cs_n = 1'b1, ale = 1'b0, a1 = 1'b0, wr_rd = 1'b0, ds_n = 1'b1;
    logic [15:0] ad_in = '0;
    logic [15:0] ad_out;
    logic ad_oe, rdy_low_oe, irq_low_oe;
    logic [7:0] status_set = '0;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    logic little = 1'b0;
    logic [15:0] model [8];

    hb_slave u0 (.clk(clk), .rst_n(rst_n), .mode_generic(mode_generic), .cs_n(cs_n),
        .ale(ale), .a1(a1), .wr_rd(wr_rd), .ds_n(ds_n), .ad_in(ad_in), .ad_out(ad_out),
        .ad_oe(ad_oe), .rdy_low_oe(rdy_low_oe), .status_set(status_set), .irq_low_oe(irq_low_oe));

    always #5 clk = ~clk;

    function automatic logic [15:0] sw(input logic [15:0] v);
        return little ? v : {v[7:0], v[15:8]};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Fixed-length access; checks ready timing and read-enable placement.
    task automatic s_cycle(input logic wr, input int idx, input logic [1:0] low,
                           input logic [15:0] wd, output logic [15:0] rd);
        int rdy_n;
        rdy_n = 0;
        @(negedge clk); mode_generic = 0; cs_n = 0; ale = 1; wr_rd = wr;
        ad_in = 16'((idx >> 1) << 2) | 16'(low); a1 = idx[0];
        @(negedge clk); ale = 0; ad_in = wr ? wd : 16'h0;
        for (int k = 0; k < 4; k++) begin
            chk(rdy_low_oe == 0, "R2 ready floated in wait", 16'(rdy_low_oe), 0);
            if (k < 3) @(negedge clk);
        end
        @(negedge clk);
        chk(rdy_low_oe == 1, "R2 ready in data phase", 16'(rdy_low_oe), 1);
        chk(ad_oe == !wr, "R11 bus enable in data phase", 16'(ad_oe), 16'(!wr));
        rd = ad_out;
        @(negedge clk);
        chk(rdy_low_oe == 1 && ad_oe == 0, "R2 ready in recovery", 16'(rdy_low_oe), 1);
        @(negedge clk);
        chk(rdy_low_oe == 0, "R2 ready released", 16'(rdy_low_oe), 0);
        cs_n = 1;
    endtask

    // Generic strobe-paced access.
    task automatic g_cycle(input logic wr, input int idx, input logic [15:0] wd, output logic [15:0] rd);
        @(negedge clk); mode_generic = 1; cs_n = 0; ale = 1; wr_rd = wr;
        ad_in = 16'((idx >> 1) << 2); a1 = idx[0];
        @(negedge clk); ale = 0; ad_in = wr ? wd : 16'h0; ds_n = 0;
        #1;
        chk(ad_oe == !wr, "R6 generic read drive", 16'(ad_oe), 16'(!wr));
        chk(rdy_low_oe == 0, "R6 no ready in generic", 16'(rdy_low_oe), 0);
        rd = ad_out;
        @(negedge clk); ds_n = 1; ad_in = 16'hDEAD;
        #1;
        chk(ad_oe == 0, "R6 drive ends with strobe", 16'(ad_oe), 0);
        @(negedge clk); cs_n = 1;
    endtask

    task automatic acc(input logic gen, input logic wr, input int idx, input logic [15:0] wd,
                       output logic [15:0] rd);
        if (gen) g_cycle(wr, idx, wd, rd);
        else     s_cycle(wr, idx, 2'($urandom_range(0, 3)), wd, rd);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=%h expected=%h", 16'h1, 16'h0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [15:0] r;
        void'($urandom(32'd1234));
        for (int i = 0; i < 8; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(rdy_low_oe == 0 && irq_low_oe == 0 && ad_oe == 0, "R1 pads released", {13'b0, rdy_low_oe, irq_low_oe, ad_oe}, 0);
        s_cycle(0, 0, 2'b00, 0, r); chk(r == 16'h0, "R1 control reads big endian", r, 0);
        s_cycle(0, 1, 2'b00, 0, r); chk(r == 16'h0, "R1 enable reset", r, 0);
        s_cycle(0, 2, 2'b00, 0, r); chk(r == 16'h0, "R1 status reset", r, 0);

        // R3 address bits: bus bits 1:0 ignored, a1 selects word
        s_cycle(1, 5, 2'b11, 16'h1234, r); model[5] = sw(16'h1234);
        s_cycle(0, 5, 2'b00, 0, r); chk(r == 16'h1234, "R3 low bus bits ignored", r, 16'h1234);
        s_cycle(0, 4, 2'b10, 0, r); chk(r == 16'h0000, "R3 a1 selects word", r, 0);

        // R7 abort mid-wait
        @(negedge clk); mode_generic = 0; cs_n = 0; ale = 1; wr_rd = 1; ad_in = 16'h0008; a1 = 1;
        @(negedge clk); ale = 0; ad_in = 16'hBEEF;
        @(negedge clk); cs_n = 1;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (rdy_low_oe) chk(0, "R7 ready during abort", 1, 0);
        end
        s_cycle(0, 5, 2'b00, 0, r); chk(r == 16'h1234, "R7 aborted write ignored", r, 16'h1234);

        // R10 out of range
        s_cycle(1, 21, 2'b00, 16'h5555, r);
        s_cycle(0, 21, 2'b00, 0, r); chk(r == 16'h0, "R10 out of range reads zero", r, 0);
        s_cycle(0, 5, 2'b00, 0, r); chk(r == 16'h1234, "R10 alias unchanged", r, 16'h1234);

        // R8 / R9 status and interrupt (big endian: reg byte in bus[15:8])
        @(negedge clk); status_set = 8'h09; @(negedge clk); status_set = 8'h00;
        s_cycle(0, 2, 2'b00, 0, r); chk(r == 16'h0900, "R8 status set", r, 16'h0900);
        chk(irq_low_oe == 0, "R9 no irq when disabled", 16'(irq_low_oe), 0);
        s_cycle(1, 1, 2'b00, 16'h0800, r);
        @(negedge clk); chk(irq_low_oe == 1, "R9 irq with enable", 16'(irq_low_oe), 1);
        s_cycle(1, 2, 2'b00, 16'h0100, r);
        s_cycle(0, 2, 2'b00, 0, r); chk(r == 16'h0800, "R8 write one clears bit", r, 16'h0800);
        chk(irq_low_oe == 1, "R9 irq held", 16'(irq_low_oe), 1);
        g_cycle(1, 2, 16'h0800, r);
        @(negedge clk); chk(irq_low_oe == 0, "R9 irq released", 16'(irq_low_oe), 0);

        // R5 switch to little endian: register bit 0 arrives in bus[8]
        s_cycle(1, 0, 2'b00, 16'h0100, r); little = 1;
        s_cycle(0, 0, 2'b00, 0, r); chk(r == 16'h0001, "R5 little endian selected", r, 16'h0001);
        s_cycle(0, 5, 2'b00, 0, r); chk(r == 16'h3412, "R5 bytes follow order", r, 16'h3412);

        // R4 / R6 random traffic across modes and byte orders
        for (int it = 0; it < 80; it++) begin
            logic gen;
            int idx;
            logic [15:0] d;
            gen = 1'($urandom_range(0, 1));
            idx = $urandom_range(3, 7);
            d = 16'($urandom());
            case ($urandom_range(0, 5))
                0: begin
                    acc(gen, 1, 0, little ? 16'h0000 : 16'h0100, r);
                    little = !little;
                end
                1, 2: begin acc(gen, 1, idx, d, r); model[idx] = sw(d); end
                default: begin
                    acc(gen, 0, idx, 0, r);
                    chk(r == sw(model[idx]), gen ? "R6 generic read back" : "R4 fixed read back", r, sw(model[idx]));
                end
            endcase
        end

        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule